// File: doc/BRIEF.md
# Bit-Serial Distributed-Arithmetic Inner-Product Unit

This block forms the sum of products of several unsigned input samples with the same number of fixed coefficients, and it has no multiplier. The coefficients are design parameters. From them the block builds a lookup table whose every entry is the sum of one subset of the coefficients. On a start pulse the samples are loaded into per-tap shift registers. On each following clock, the lowest bit of every sample forms a table address. The entry that address selects is added into an accumulator, and the sum is shifted one place right. The bit that drops off the low end is kept, so the final result is exact.

A controller walks through three named states. `PH_IDLE` waits for a start. `PH_RUN` performs one table look-up and accumulate per sample bit. `PH_FINISH` raises the completion pulse for one cycle. The transitions are as follows. `PH_IDLE -> PH_RUN` happens on an accepted start. `PH_RUN -> PH_RUN` happens while slices remain. `PH_RUN -> PH_FINISH` happens after the last slice. `PH_FINISH -> PH_IDLE` happens always. The user applies samples, pulses start, waits for the done pulse and reads the result, which holds until the next accepted start.

Top module: `dafir_mac`

## Requirements
- R1: Table entry k equals the sum of the coefficients c[n] for which bit n of k is 1, so entry 0 is zero. Address bit n is taken from sample n: sample 0 drives the address LSB.
- R2: Samples are unsigned. One bit-slice is consumed per clock, starting from bit 0 (the LSB) and ending with bit SAMPLE_W-1.
- R3: When start is accepted at clock edge k, done is high in the cycle that follows edge k+SAMPLE_W.
- R4: In the done cycle, result equals the sum over n of c[n]·x[n], held without loss in SAMPLE_W+ACCW bits. ACCW is CW+clog2(NTAPS)+1. The accumulator never exceeds the coefficient total.
- R5: done is high for exactly one cycle per accepted start.
- R6: A start that arrives while busy is high (in `PH_RUN` or `PH_FINISH`) is ignored. It causes no restart and no extra done.
- R7: busy is high from the cycle after an accepted start through the done cycle, and low in `PH_IDLE`.
- R8: result holds its value from the done cycle until the next accepted start.
- R9: After reset, busy, done and result are all zero.
- R10: Samples are captured on the accepted start. Changes to the samples input during a computation have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a computation (accepted only when idle) |
| samples | input | NTAPS*SAMPLE_W | Unsigned samples; sample n at bits [n*SAMPLE_W +: SAMPLE_W] |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | SAMPLE_W+ACCW | Inner product |

## Verification
Samples with a single nonzero tap, and with a single set bit at the LSB or the MSB, show whether the address bit order and the bit-slice order are right. A wrong mapping picks the wrong coefficient, and a wrong order gives a wrongly weighted result. The worked three-tap case (2,3,1 times 1,3,7 giving 18) together with random vectors checks the shift-add arithmetic against a direct multiply-accumulate model. All-zero and all-ones samples check the empty table entry and the largest accumulation, where a lost carry or a dropped low bit would show. A run in which start is held high and the samples are flipped mid-computation separates correct capture from restart or from live sampling.

// File: rtl/dafir_pkg.sv
package dafir_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_RUN    = 2'd1,
        PH_FINISH = 2'd2
    } dafir_phase_e;

endpackage

// File: rtl/dafir_table.sv
module dafir_table #(
    parameter int NTAPS = 4,
    parameter int CW    = 8,
    parameter int SUMW  = 10,
    parameter logic [NTAPS*CW-1:0] COEFS = '0
) (
    input  logic [NTAPS-1:0] addr,
    output logic [SUMW-1:0]  value
);
    localparam int DEPTH = 1 << NTAPS;

    // R1: entry k is the sum of the coefficients selected by the set bits of k
    function automatic logic [SUMW-1:0] entry_of(input int idx);
        logic [SUMW-1:0] acc;
        acc = '0;
        for (int n = 0; n < NTAPS; n++) begin
            if (((idx >> n) & 1) == 1)
                acc = acc + SUMW'(COEFS[n*CW +: CW]);
        end
        return acc;
    endfunction

    logic [SUMW-1:0] rom [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        assign rom[e] = entry_of(e);
    end

    assign value = rom[addr];

endmodule

// File: rtl/dafir_slicer.sv
module dafir_slicer #(
    parameter int NTAPS    = 4,
    parameter int SAMPLE_W = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic                      step,
    input  logic [NTAPS*SAMPLE_W-1:0] samples,
    output logic [NTAPS-1:0]          addr
);
    for (genvar n = 0; n < NTAPS; n++) begin : g_lane
        logic [SAMPLE_W-1:0] lane;

        // R10: capture on load only; R2: LSB first, one bit per step
        always_ff @(posedge clk) begin
            if (!rst_n)
                lane <= '0;
            else if (load)
                lane <= samples[n*SAMPLE_W +: SAMPLE_W];
            else if (step)
                lane <= lane >> 1;
        end

        assign addr[n] = lane[0];
    end

endmodule

// File: rtl/dafir_accum.sv
module dafir_accum #(
    parameter int SUMW       = 10,
    parameter int ACCW       = 11,
    parameter int SAMPLE_W   = 6,
    parameter int COEF_TOTAL = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                step,
    input  logic [SUMW-1:0]     part,
    output logic [ACCW-1:0]     acc,
    output logic [SAMPLE_W-1:0] low
);
    logic [ACCW-1:0] sum;

    assign sum = acc + ACCW'(part);

    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            acc <= '0;
        else if (step)
            acc <= {1'b0, sum[ACCW-1:1]};
    end

    if (SAMPLE_W == 1) begin : g_low_one
        always_ff @(posedge clk) begin
            if (!rst_n || clear)
                low <= '0;
            else if (step)
                low <= sum[0];
        end
    end else begin : g_low_many
        always_ff @(posedge clk) begin
            if (!rst_n || clear)
                low <= '0;
            else if (step)
                low <= {sum[0], low[SAMPLE_W-1:1]};
        end
    end

    // R4: shifting right keeps the accumulator within the coefficient total
    assert_acc_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(acc) <= COEF_TOTAL);

    // R8: without clear or step the accumulated value holds
    assert_acc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !step) |=> ($stable(acc) && $stable(low)));

endmodule

// File: rtl/dafir_ctrl.sv
module dafir_ctrl
    import dafir_pkg::*;
#(
    parameter int SAMPLE_W = 6,
    localparam int CNTW = (SAMPLE_W > 1) ? $clog2(SAMPLE_W) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    localparam logic [CNTW-1:0] LAST = CNTW'(SAMPLE_W - 1);

    dafir_phase_e    state, state_nx;
    logic [CNTW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PH_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (load)
                cnt <= '0;
            else if (step)
                cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            PH_IDLE:   if (start) state_nx = PH_RUN;
            PH_RUN:    if (cnt == LAST) state_nx = PH_FINISH;
            PH_FINISH: state_nx = PH_IDLE;
            default:   state_nx = PH_IDLE;
        endcase
    end

    always_comb begin
        load = 1'b0;
        step = 1'b0;
        busy = 1'b0;
        done = 1'b0;
        unique case (state)
            PH_IDLE:   load = start;
            PH_RUN:    begin step = 1'b1; busy = 1'b1; end
            PH_FINISH: begin busy = 1'b1; done = 1'b1; end
            default:   ;
        endcase
    end

    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R3: slices advance one per cycle until the last one
    assert_slice_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_RUN && cnt != LAST) |=> (state == PH_RUN && cnt == $past(cnt) + 1'b1));

    assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> !(state == PH_RUN && cnt == '0));

endmodule

// File: rtl/dafir_mac.sv
module dafir_mac #(
    parameter int NTAPS    = 4,
    parameter int SAMPLE_W = 6,
    parameter int CW       = 8,
    parameter logic [NTAPS*CW-1:0] COEFS = {8'd255, 8'd1, 8'd3, 8'd2},
    localparam int SUMW = CW + $clog2(NTAPS),
    localparam int ACCW = SUMW + 1,
    localparam int RESW = SAMPLE_W + ACCW
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [NTAPS*SAMPLE_W-1:0] samples,
    output logic                      busy,
    output logic                      done,
    output logic [RESW-1:0]           result
);
    function automatic int coef_total();
        int t;
        t = 0;
        for (int n = 0; n < NTAPS; n++)
            t += int'(COEFS[n*CW +: CW]);
        return t;
    endfunction

    localparam int COEF_TOTAL = coef_total();

    logic                load, step;
    logic [NTAPS-1:0]    addr;
    logic [SUMW-1:0]     part;
    logic [ACCW-1:0]     acc;
    logic [SAMPLE_W-1:0] low;

    dafir_ctrl #(.SAMPLE_W(SAMPLE_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .load(load), .step(step), .busy(busy), .done(done)
    );

    dafir_slicer #(.NTAPS(NTAPS), .SAMPLE_W(SAMPLE_W)) u_slicer (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .samples(samples), .addr(addr)
    );

    dafir_table #(.NTAPS(NTAPS), .CW(CW), .SUMW(SUMW), .COEFS(COEFS)) u_table (
        .addr(addr), .value(part)
    );

    dafir_accum #(.SUMW(SUMW), .ACCW(ACCW), .SAMPLE_W(SAMPLE_W),
                  .COEF_TOTAL(COEF_TOTAL)) u_accum (
        .clk(clk), .rst_n(rst_n), .clear(load), .step(step),
        .part(part), .acc(acc), .low(low)
    );

    assign result = {acc, low};

    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(result));

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !done);

endmodule

// File: tb/sim_dafir_mac.sv
module sim_dafir_mac;
    localparam int NT   = 4;
    localparam int SW   = 6;
    localparam int CW   = 8;
    localparam int RESW = SW + CW + 2 + 1;
    localparam logic [NT*CW-1:0] CO = {8'd255, 8'd1, 8'd3, 8'd2};

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [NT*SW-1:0]   samples = '0;
    logic               busy, done;
    logic [RESW-1:0]    result;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    logic [RESW-1:0] exp_q[$];
    int              when_q[$];
    string           tag_q[$];

    dafir_mac #(.NTAPS(NT), .SAMPLE_W(SW), .CW(CW), .COEFS(CO)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .samples(samples),
        .busy(busy), .done(done), .result(result)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [RESW-1:0] ref_mac(input logic [NT*SW-1:0] s);
        int t;
        t = 0;
        for (int n = 0; n < NT; n++)
            t += int'(CO[n*CW +: CW]) * int'(s[n*SW +: SW]);
        return RESW'(t);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every done pulse
    logic prev_done = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (done && prev_done)
                check(1'b0, "R5 done longer than one cycle", 1, 0);
            if (done) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 unexpected done", 1, 0);
                end else begin
                    logic [RESW-1:0] e;
                    int    w;
                    string t;
                    e = exp_q.pop_front();
                    w = when_q.pop_front();
                    t = tag_q.pop_front();
                    check(result == e, t, result, e);
                    check(cyc - w == SW + 1, "R3 latency", cyc - w, SW + 1);
                    check(busy == 1'b1, "R7 busy in done cycle", busy, 1);
                end
            end
        end
        prev_done <= done;
    end

    task automatic issue(input logic [NT*SW-1:0] s, input string tag, input bit disturb);
        logic [RESW-1:0] held;
        while (busy) @(negedge clk);
        exp_q.push_back(ref_mac(s));
        when_q.push_back(cyc);
        tag_q.push_back(tag);
        samples = s;
        start = 1'b1;
        @(negedge clk);
        check(busy == 1'b1, "R7 busy after start", busy, 1);
        if (disturb) begin
            // R6 R10: keep start high and change the samples during the run
            samples = ~s;
        end else begin
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b0, "R7 busy low after done", busy, 0);
        check(done == 1'b0, "R5 done dropped", done, 0);
        held = result;
        samples = ~samples;
        repeat (3) @(negedge clk);
        check(result == held, "R8 result held", result, held);
        check(done == 1'b0, "R6 no second done", done, 0);
    endtask

    function automatic logic [NT*SW-1:0] pack(input int a, input int b, input int c, input int d);
        return {SW'(d), SW'(c), SW'(b), SW'(a)};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R9 busy at reset", busy, 0);
        check(done == 1'b0, "R9 done at reset", done, 0);
        check(result == '0, "R9 result at reset", result, 0);
        rst_n = 1'b1;
        @(negedge clk);

        issue(pack(1, 3, 7, 0), "R4 worked example 18", 1'b0);
        check(result == RESW'(18), "R4 worked example value", result, 18);
        issue(pack(1, 0, 0, 0), "R1 tap0 address LSB", 1'b0);
        issue(pack(0, 1, 0, 0), "R1 tap1", 1'b0);
        issue(pack(0, 0, 0, 1), "R1 tap3 address MSB", 1'b0);
        issue(pack(0, 32, 0, 0), "R2 sample MSB slice", 1'b0);
        issue(pack(32, 0, 0, 1), "R2 MSB and LSB slices", 1'b0);
        issue(pack(0, 0, 0, 0), "R4 all zero", 1'b0);
        issue(pack(63, 63, 63, 63), "R4 all ones", 1'b0);
        issue(pack(5, 17, 40, 9), "R10 R6 start held and samples changed", 1'b1);
        for (int i = 0; i < 30; i++)
            issue(NT*SW'($urandom), "R4 random", (i % 7) == 3);

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R5 missing done", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule